// File: doc/BRIEF.md
# Tiled Buffered Vector Adder

This block computes an element-wise sum C = A + B over three signed 32-bit vectors held in an external word-addressed memory. One start command, carrying the element count and three base addresses, processes the whole vector. The block then raises a one-cycle done pulse. The memory is seen through two ports. The read port has a request channel with valid/ready handshake and an in-order response channel. The write port has a valid/ready handshake.

The work proceeds in tiles of up to 256 elements. For each tile the block first fetches the A slice into a local buffer. It then fetches the B slice into a second local buffer. Only after both are loaded does it stream the sums out to C. When the element count is not a multiple of the tile size, the final tile is shortened to the remainder.

The controller has six states: IDLE, LOAD_A, LOAD_B, COMPUTE_WRITE, NEXT_TILE and DONE. The transitions are:

- IDLE goes to LOAD_A on start with a non-zero count, and to DONE on start with a zero count.
- LOAD_A goes to LOAD_B when the last A response of the tile arrives.
- LOAD_B goes to COMPUTE_WRITE when the last B response arrives.
- COMPUTE_WRITE goes to NEXT_TILE when the last sum is accepted.
- NEXT_TILE goes to LOAD_A if elements remain, otherwise to DONE.
- DONE always returns to IDLE after one cycle.

Top module: `vta_adder`

## Requirements
- R1: One accepted start processes all `length` elements. `busy` is high from the cycle after the start until the cycle after the done pulse.
- R2: Tile bases step by 256 from 0 while the base is below `length`. A tile holds 256 elements, except the final tile, which holds `length` minus its base.
- R3: Within a tile, all read requests for A (addresses `a_base`+base+j, j ascending) are issued before any request for B (`b_base`+base+j, j ascending). All B responses arrive before any write is issued. A read request and a write are never valid in the same cycle.
- R4: Each element i of C is written once, at address `c_base`+i, with data equal to A[i]+B[i] modulo 2^32. No other address is written.
- R5: A start with `length` equal to 0 raises `done` in the next cycle and issues no read and no write.
- R6: `done` is high for exactly one cycle per run, after which the block is idle.
- R7: `start`, and any new `length` or base values presented with it, are ignored while `busy` is high.
- R8: A read request stalled by low `rd_req_ready` keeps its address until it is accepted. Responses fill the buffer in request order.
- R9: A write stalled by low `wr_ready` keeps its address and data until it is accepted.
- R10: After reset, `busy`, `done`, `rd_req_valid` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, taken only when idle |
| length | input | LEN_W | Element count, sampled at start |
| a_base | input | ADDR_W | Word address of A |
| b_base | input | ADDR_W | Word address of B |
| c_base | input | ADDR_W | Word address of C |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_req_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | DATA_W | Returned read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | DATA_W | Write data (sum) |

## Verification
The assertions assume that the memory returns exactly one response per accepted read request, in request order, and never a response ahead of its request. They also assume that the three vector regions do not overlap. The bench memory model respects both assumptions. It queues each accepted address and pops at most one entry per cycle, with random latency. The bench places A, B and C in disjoint 1024-word windows and keeps every length within a window. Random ready and response timing exercises the stall holding of R8 and R9 without breaking these assumptions.

// File: rtl/vta_pkg.sv
package vta_pkg;
    typedef enum logic [2:0] {
        IDLE,
        LOAD_A,
        LOAD_B,
        COMPUTE_WRITE,
        NEXT_TILE,
        DONE
    } vta_state_t;
endpackage

// File: rtl/vta_buf.sv
module vta_buf #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vta_tile_len.sv
module vta_tile_len #(
    parameter int LEN_W = 16,
    parameter int TILE  = 256,
    parameter int CNT_W = 9
) (
    input  logic [LEN_W-1:0] base,
    input  logic [LEN_W-1:0] total,
    output logic [CNT_W-1:0] cnt
);
    logic [LEN_W:0] rem;

    always_comb begin
        rem = {1'b0, total} - {1'b0, base};
        if (rem > (LEN_W+1)'(TILE)) cnt = CNT_W'(TILE);
        else                        cnt = CNT_W'(rem);
    end
endmodule

// File: rtl/vta_adder.sv
module vta_adder
    import vta_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TILE   = 256,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  length,
    input  logic [ADDR_W-1:0] a_base,
    input  logic [ADDR_W-1:0] b_base,
    input  logic [ADDR_W-1:0] c_base,
    output logic              busy,
    output logic              done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int IDX_W = $clog2(TILE);
    localparam int CNT_W = $clog2(TILE + 1);
    localparam int NBUF  = 2;

    vta_state_t state, state_n;

    logic [LEN_W-1:0]  len_q, tile_base;
    logic [ADDR_W-1:0] a_q, b_q, c_q;
    logic [CNT_W-1:0]  iss, ret, wix, tcnt;
    logic [DATA_W-1:0] rdat [NBUF];
    logic              load_fin, write_fin, last_tile, rd_fire, wr_fire;

    vta_tile_len #(.LEN_W(LEN_W), .TILE(TILE), .CNT_W(CNT_W)) u_tlen (
        .base (tile_base),
        .total(len_q),
        .cnt  (tcnt)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        localparam vta_state_t FILL_ST = (g == 0) ? LOAD_A : LOAD_B;
        vta_buf #(.DEPTH(TILE), .W(DATA_W)) u_buf (
            .clk  (clk),
            .we   (rd_rsp_valid && state == FILL_ST),
            .waddr(ret[IDX_W-1:0]),
            .wdata(rd_rsp_data),
            .raddr(wix[IDX_W-1:0]),
            .rdata(rdat[g])
        );
    end

    assign rd_fire   = rd_req_valid && rd_req_ready;
    assign wr_fire   = wr_valid && wr_ready;
    assign load_fin  = rd_rsp_valid && (ret == tcnt - CNT_W'(1));
    assign write_fin = wr_fire && (wix == tcnt - CNT_W'(1));
    assign last_tile = ({1'b0, tile_base} + (LEN_W+1)'(TILE)) >= {1'b0, len_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            IDLE:          if (start) state_n = (length == '0) ? DONE : LOAD_A;
            LOAD_A:        if (load_fin) state_n = LOAD_B;
            LOAD_B:        if (load_fin) state_n = COMPUTE_WRITE;
            COMPUTE_WRITE: if (write_fin) state_n = NEXT_TILE;
            NEXT_TILE:     state_n = last_tile ? DONE : LOAD_A;
            DONE:          state_n = IDLE;
            default:       state_n = IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            c_q       <= '0;
            tile_base <= '0;
            iss       <= '0;
            ret       <= '0;
            wix       <= '0;
        end else begin
            if (state == IDLE && start) begin
                len_q     <= length;
                a_q       <= a_base;
                b_q       <= b_base;
                c_q       <= c_base;
                tile_base <= '0;
            end
            if (state == NEXT_TILE) tile_base <= tile_base + LEN_W'(TILE);
            if (state != state_n) begin
                iss <= '0;
                ret <= '0;
                wix <= '0;
            end else begin
                if (rd_fire)      iss <= iss + CNT_W'(1);
                if (rd_rsp_valid) ret <= ret + CNT_W'(1);
                if (wr_fire)      wix <= wix + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy         = (state != IDLE);
        done         = (state == DONE);
        rd_req_valid = 1'b0;
        rd_req_addr  = '0;
        wr_valid     = 1'b0;
        wr_addr      = c_q + ADDR_W'(tile_base) + ADDR_W'(wix);
        wr_data      = rdat[0] + rdat[1];
        unique case (state)
            LOAD_A: begin
                rd_req_valid = (iss < tcnt);
                rd_req_addr  = a_q + ADDR_W'(tile_base) + ADDR_W'(iss);
            end
            LOAD_B: begin
                rd_req_valid = (iss < tcnt);
                rd_req_addr  = b_q + ADDR_W'(tile_base) + ADDR_W'(iss);
            end
            COMPUTE_WRITE: wr_valid = 1'b1;
            default: ;
        endcase
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    // R5
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && length == '0) |=> done && !rd_req_valid && !wr_valid);
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(len_q) && $stable(c_q));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr));
    // R8
    rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid |-> (ret < iss));
    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && wr_valid));
    // R2
    tile_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && state != NEXT_TILE) |-> (tcnt != '0 && tcnt <= CNT_W'(TILE)));
endmodule

// File: tb/sim_vta_adder.sv
module sim_vta_adder;
    localparam int DW = 32, LW = 16, AW = 16;
    localparam int ABASE = 0, BBASE = 1024, CBASE = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] length = '0;
    logic [AW-1:0] a_base = AW'(ABASE), b_base = AW'(BBASE), c_base = AW'(CBASE);
    logic busy, done, rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
    logic [AW-1:0] rd_req_addr, wr_addr;
    logic [DW-1:0] rd_rsp_data = '0, wr_data;
    logic wr_valid, wr_ready = 1'b0;

    always #2 clk = ~clk;

    vta_adder u0 (.*);

    int tests = 0, fails = 0;
    logic [DW-1:0] mem [4096];
    int rlog [4096];
    int rcnt, wcnt, wbad, dcnt, qh, qt;
    int q [4096];
    int rdy_pct = 60;

    // memory model: decides handshakes at the falling edge for the next rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_req_ready = 1'b0; wr_ready = 1'b0; rd_rsp_valid = 1'b0;
        end else begin
            rd_req_ready = ($urandom_range(99) < rdy_pct);
            wr_ready     = ($urandom_range(99) < rdy_pct);
            if (qh != qt && $urandom_range(99) < 70) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem[q[qh % 4096] % 4096];
                qh++;
            end else begin
                rd_rsp_valid = 1'b0;
            end
            if (rd_req_valid && rd_req_ready) begin
                q[qt % 4096] = int'(rd_req_addr);
                qt++;
                if (rcnt < 4096) rlog[rcnt] = int'(rd_req_addr);
                rcnt++;
            end
            if (wr_valid && wr_ready) begin
                if (int'(wr_addr) < CBASE || int'(wr_addr) >= CBASE + 1024) wbad++;
                mem[int'(wr_addr) % 4096] = wr_data;
                wcnt++;
            end
            if (done) dcnt++;
        end
    end

    function automatic int tile_n(int base, int len);
        return (len - base > 256) ? 256 : len - base;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(int len, bit restart_mid);
        int cyc = 0, bad = 0, first_bad = -1, seq_bad = 0, k = 0, busy_gap = 0;
        for (int i = 0; i < 1024; i++) begin
            mem[ABASE + i] = $urandom;
            mem[BBASE + i] = $urandom;
            mem[CBASE + i] = 32'hDEAD_BEEF;
        end
        if (len < 1024) begin
            mem[ABASE + len] = 32'h7FFF_FFFF;
            mem[BBASE + len] = 32'h0000_0001;
        end
        rcnt = 0; wcnt = 0; wbad = 0; dcnt = 0; qh = 0; qt = 0;
        @(negedge clk);
        length = LW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0; length = '0;
        if (len != 0 && !busy) busy_gap = 1;
        while (dcnt == 0 && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (restart_mid && cyc == 30) begin
                length = 16'd3; start = 1'b1;
            end
            if (restart_mid && cyc == 31) begin
                start = 1'b0; length = '0;
            end
            if (dcnt == 0 && !busy) busy_gap = 1;
        end
        if (cyc >= 40000) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: actual %0d expected done", cyc);
            return;
        end
        if (len == 0) check(cyc <= 1, "R5", "done latency", cyc, 1);
        repeat (8) @(negedge clk);
        check(!busy, "R6", "idle after done", int'(busy), 0);
        check(dcnt == 1, "R6 R7", "done pulses", dcnt, 1);
        check(busy_gap == 0, "R1", "busy held during run", busy_gap, 0);
        for (int i = 0; i < len; i++)
            if (mem[CBASE + i] !== mem[ABASE + i] + mem[BBASE + i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, "R4", "sum mismatches", bad, 0);
        for (int i = len; i < 1024; i++)
            if (mem[CBASE + i] !== 32'hDEAD_BEEF) bad++;
        check(bad == 0 && wbad == 0 && wcnt == len, "R4 R7", "writes", wcnt, len);
        check(rcnt == 2 * len, "R2", "read count", rcnt, 2 * len);
        for (int t = 0; t < len; t += 256) begin
            for (int j = 0; j < tile_n(t, len); j++) begin
                if (k >= 4096 || rlog[k] != ABASE + t + j) seq_bad++;
                k++;
            end
            for (int j = 0; j < tile_n(t, len); j++) begin
                if (k >= 4096 || rlog[k] != BBASE + t + j) seq_bad++;
                k++;
            end
        end
        check(seq_bad == 0, "R3 R8", "read order errors", seq_bad, 0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_req_valid && !wr_valid, "R10", "reset outputs",
              int'({busy, done, rd_req_valid, wr_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(0, 0);
        run(1, 0);
        run(255, 0);
        run(256, 0);
        run(257, 1);
        rdy_pct = 25;
        run(512, 0);
        rdy_pct = 90;
        run(600, 1);
        for (int r = 0; r < 4; r++) begin
            rdy_pct = 20 + $urandom_range(79);
            run($urandom_range(1, 1000), r[0]);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule